// File: doc/BRIEF.md
# Time-Interleaved SAR Conversion Sequencer

This block schedules sixteen identical successive-approximation conversion sections from one input clock. A shared phase counter runs round the sixteen phases. Each section reads its own position in that rotation, offset by its index, and works through a fixed sixteen-slot program. The first three slots are calibration work: a reference-zero sample, an auto-zero comparison and an auto-calibrate comparison. The fourth slot samples the input. Nine slots resolve the code one bit at a time, two slots hold the result, and the last slot transfers it. Because neighbouring sections are one clock apart, exactly one section samples the input on every clock.

For each section the block drives the timing strobes and a 9-bit trial code for that section's DAC. It takes back the section's comparator decision, and keeps the finished code in a per-section result register. The result leaves as a valid-only stream: the transfer strobe acts as valid and the data is on `result_o`. There is no ready input and no back-pressure, because the analog timing cannot stall. A consumer must take each word in its transfer cycle, and it can still read the word from the result register until that section finishes its next conversion.

After reset, a section's first transfer is meaningful only if its sample slot came after reset was released.

Top module: `tis_seq_top`

## Requirements
- R1: `phase_o` is 0 in the first cycle after reset and steps by one each clock, wrapping from NSEC-1 to 0.
- R2: Section k samples (`smp_o[k]`=1) exactly when `phase_o` equals (k+3) mod NSEC, so exactly one bit of `smp_o` is set in every cycle.
- R3: For each section, the reference-zero strobe is high at phase k, the auto-zero strobe at phase k+1 and the calibrate strobe at phase k+2 (mod NSEC). The three strobes follow each other on consecutive clocks.
- R4: A section raises at most one of its five strobes in any cycle, and each strobe vector is one-hot across sections.
- R5: In the slot after sampling, the trial code is 0x100, meaning only bit 8 is set. Bits are then decided MSB first, one per clock, in slots 5 to 13.
- R6: A comparator decision of 1 (input at or above the trial level) keeps the bit under test. A decision of 0 clears it before the next lower bit is set.
- R7: The transfer strobe `xfer_o[k]` is high for one clock at phase (k+15) mod NSEC, and exactly one section transfers per cycle.
- R8: The trial code is 0 in slots 1 to 4. It holds the final code in slots 14 to 16 and returns to 0 after the transfer slot.
- R9: A synchronous reset forces the phase to 0 and clears every trial code and result register on the next edge.
- R10: With ideal comparisons, the result presented at transfer equals the 9-bit level sampled twelve clocks earlier, for any level from 0 to 511. A comparator held at 1 yields 0x1FF, and one held at 0 yields 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; everything advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | NSEC | Comparator decision of each section |
| phase_o | output | log2(NSEC) | Shared rotation phase |
| refz_o | output | NSEC | Reference-zero sample strobe per section |
| azero_o | output | NSEC | Auto-zero comparison strobe per section |
| cal_o | output | NSEC | Auto-calibrate comparison strobe per section |
| smp_o | output | NSEC | Input sample strobe per section |
| xfer_o | output | NSEC | Transfer strobe / result valid per section |
| trial_o | output | NSEC*NBITS | Trial code per section, section k at bits k*NBITS upward |
| result_o | output | NSEC*NBITS | Result register per section, same packing |

## Verification
Two functions meet in one cycle. Section k transfers its result while section k+12 samples a new input level, and both are driven from the same shared phase. The bench changes the input level on every clock and rotates the pattern between rounds, so any mix-up in which sample feeds which transfer shows up as a wrong result word. The bench also places the comparator-forced rounds next to normal rounds, so sections that are mid-conversion in different modes sit side by side in the same clock.

// File: rtl/tis_pkg.sv
package tis_pkg;
  localparam int unsigned SEC_N_DEF = 16;
  localparam int unsigned BITS_DEF  = 9;

  localparam int unsigned SLOT_REFZ  = 0;
  localparam int unsigned SLOT_AZ    = 1;
  localparam int unsigned SLOT_CAL   = 2;
  localparam int unsigned SLOT_SMP   = 3;
  localparam int unsigned SLOT_CONV0 = 4;

  typedef enum logic [2:0] {
    SK_REFZ, SK_AZ, SK_CAL, SK_SMP, SK_CONV, SK_HOLD, SK_XFER
  } slot_kind_t;
endpackage

// File: rtl/tis_phase.sv
module tis_phase #(
  parameter int unsigned NSEC = 16,
  localparam int unsigned PW = $clog2(NSEC)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase_o
);
  always_ff @(posedge clk) begin
    if (rst)                         phase_o <= '0;
    else if (phase_o == PW'(NSEC-1)) phase_o <= '0;
    else                             phase_o <= phase_o + 1'b1;
  end
endmodule

// File: rtl/tis_slot.sv
module tis_slot
  import tis_pkg::*;
#(
  parameter int unsigned NSEC  = 16,
  parameter int unsigned NBITS = 9,
  parameter int unsigned SECT  = 0,
  localparam int unsigned PW = $clog2(NSEC),
  localparam int unsigned BW = $clog2(NBITS)
) (
  input  logic [PW-1:0] phase_i,
  output slot_kind_t    kind_o,
  output logic [BW-1:0] bidx_o
);
  localparam int unsigned CONV_LAST = SLOT_CONV0 + NBITS - 1;
  localparam int unsigned XFER_SLOT = NSEC - 1;

  int unsigned s;

  always_comb begin
    s = (int'(phase_i) + NSEC - SECT) % NSEC;
    bidx_o = '0;
    if (s == SLOT_REFZ)                            kind_o = SK_REFZ;
    else if (s == SLOT_AZ)                         kind_o = SK_AZ;
    else if (s == SLOT_CAL)                        kind_o = SK_CAL;
    else if (s == SLOT_SMP)                        kind_o = SK_SMP;
    else if (s >= SLOT_CONV0 && s <= CONV_LAST) begin
      kind_o = SK_CONV;
      bidx_o = BW'(CONV_LAST - s);
    end
    else if (s == XFER_SLOT)                       kind_o = SK_XFER;
    else                                           kind_o = SK_HOLD;
  end
endmodule

// File: rtl/tis_sar.sv
module tis_sar
  import tis_pkg::*;
#(
  parameter int unsigned NBITS = 9,
  localparam int unsigned BW = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  slot_kind_t       kind_i,
  input  logic [BW-1:0]    bidx_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] trial_o,
  output logic [NBITS-1:0] result_o
);
  localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] decided;

  // Decide the bit under test and arm the next lower one.
  always_comb begin
    decided = trial_o;
    if (!cmp_i) decided[bidx_i] = 1'b0;
    if (bidx_i != '0) decided[bidx_i - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_o  <= '0;
      result_o <= '0;
    end else begin
      unique case (kind_i)
        SK_SMP:  trial_o <= MSB_ONE;
        SK_CONV: begin
          trial_o <= decided;
          if (bidx_i == '0) result_o <= decided;
        end
        SK_XFER: trial_o <= '0;
        default: trial_o <= trial_o;
      endcase
    end
  end
endmodule

// File: rtl/tis_seq_top.sv
module tis_seq_top
  import tis_pkg::*;
#(
  parameter int unsigned NSEC  = SEC_N_DEF,
  parameter int unsigned NBITS = BITS_DEF,
  localparam int unsigned PW = $clog2(NSEC),
  localparam int unsigned BW = $clog2(NBITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSEC-1:0]       cmp_i,
  output logic [PW-1:0]         phase_o,
  output logic [NSEC-1:0]       refz_o,
  output logic [NSEC-1:0]       azero_o,
  output logic [NSEC-1:0]       cal_o,
  output logic [NSEC-1:0]       smp_o,
  output logic [NSEC-1:0]       xfer_o,
  output logic [NSEC*NBITS-1:0] trial_o,
  output logic [NSEC*NBITS-1:0] result_o
);
  tis_phase #(.NSEC(NSEC)) u_phase (
    .clk(clk), .rst(rst), .phase_o(phase_o)
  );

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    slot_kind_t    kind;
    logic [BW-1:0] bidx;

    tis_slot #(.NSEC(NSEC), .NBITS(NBITS), .SECT(k)) u_slot (
      .phase_i(phase_o), .kind_o(kind), .bidx_o(bidx)
    );

    tis_sar #(.NBITS(NBITS)) u_sar (
      .clk(clk), .rst(rst), .kind_i(kind), .bidx_i(bidx), .cmp_i(cmp_i[k]),
      .trial_o(trial_o[k*NBITS +: NBITS]),
      .result_o(result_o[k*NBITS +: NBITS])
    );

    assign refz_o[k]  = (kind == SK_REFZ);
    assign azero_o[k] = (kind == SK_AZ);
    assign cal_o[k]   = (kind == SK_CAL);
    assign smp_o[k]   = (kind == SK_SMP);
    assign xfer_o[k]  = (kind == SK_XFER);
  end
endmodule

// File: rtl/tis_seq_chk.sv
module tis_seq_chk #(
  parameter int unsigned NSEC  = 16,
  parameter int unsigned NBITS = 9,
  localparam int unsigned PW = $clog2(NSEC)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [PW-1:0]         phase_o,
  input logic [NSEC-1:0]       refz_o,
  input logic [NSEC-1:0]       azero_o,
  input logic [NSEC-1:0]       cal_o,
  input logic [NSEC-1:0]       smp_o,
  input logic [NSEC-1:0]       xfer_o,
  input logic [NSEC*NBITS-1:0] trial_o,
  input logic [NSEC*NBITS-1:0] result_o
);
  localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase_o == (($past(phase_o) == PW'(NSEC-1)) ? '0 : $past(phase_o) + 1'b1));

  // R2
  one_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(smp_o) == 1);

  // R7
  one_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(xfer_o) == 1);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (phase_o == '0 && trial_o == '0 && result_o == '0));

  for (genvar k = 0; k < NSEC; k++) begin : g_chk
    // R3
    refz_then_az_chk: assert property (@(posedge clk) disable iff (rst)
      refz_o[k] |=> azero_o[k]);
    // R3
    az_then_cal_chk: assert property (@(posedge clk) disable iff (rst)
      azero_o[k] |=> cal_o[k]);
    // R2
    cal_then_smp_chk: assert property (@(posedge clk) disable iff (rst)
      cal_o[k] |=> smp_o[k]);
    // R5
    msb_first_chk: assert property (@(posedge clk) disable iff (rst)
      smp_o[k] |=> trial_o[k*NBITS +: NBITS] == MSB_ONE);
    // R8
    xfer_clear_chk: assert property (@(posedge clk) disable iff (rst)
      xfer_o[k] |=> trial_o[k*NBITS +: NBITS] == '0);
    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      $countones({refz_o[k], azero_o[k], cal_o[k], smp_o[k], xfer_o[k]}) <= 1);
  end
endmodule

bind tis_seq_top tis_seq_chk #(.NSEC(NSEC), .NBITS(NBITS)) u_chk (
  .clk(clk), .rst(rst), .phase_o(phase_o), .refz_o(refz_o), .azero_o(azero_o),
  .cal_o(cal_o), .smp_o(smp_o), .xfer_o(xfer_o), .trial_o(trial_o),
  .result_o(result_o)
);

// File: tb/tb_tis_seq_top.sv
`timescale 1ns/1ps
module tb_tis_seq_top;
  localparam int NS = 16;
  localparam int NB = 9;

  typedef struct packed {
    logic [NB-1:0] stim;
    logic [NB-1:0] expv;
  } vec_t;

  localparam vec_t TAB [16] = '{
    '{9'd0,   9'd0},   '{9'd511, 9'd511}, '{9'd256, 9'd256}, '{9'd255, 9'd255},
    '{9'd1,   9'd1},   '{9'd510, 9'd510}, '{9'd341, 9'd341}, '{9'd170, 9'd170},
    '{9'd128, 9'd128}, '{9'd384, 9'd384}, '{9'd3,   9'd3},   '{9'd508, 9'd508},
    '{9'd299, 9'd299}, '{9'd77,  9'd77},  '{9'd463, 9'd463}, '{9'd192, 9'd192}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0]    cmp;
  logic [3:0]       phase_o;
  logic [NS-1:0]    refz_o, azero_o, cal_o, smp_o, xfer_o;
  logic [NS*NB-1:0] trial_o, result_o;

  tis_seq_top dut (
    .clk(clk), .rst(rst), .cmp_i(cmp), .phase_o(phase_o), .refz_o(refz_o),
    .azero_o(azero_o), .cal_o(cal_o), .smp_o(smp_o), .xfer_o(xfer_o),
    .trial_o(trial_o), .result_o(result_o)
  );

  always #2 clk = ~clk;

  logic [NB-1:0] held [NS];
  logic [NB-1:0] expr [NS];
  int            hmode [NS];
  int total = 0;
  int bad = 0;
  bit fin = 0;

  // Ideal comparator per section, with optional forcing.
  always_comb begin
    for (int k = 0; k < NS; k++) begin
      if (hmode[k] == 1)      cmp[k] = 1'b1;
      else if (hmode[k] == 2) cmp[k] = 1'b0;
      else                    cmp[k] = (held[k] >= trial_o[k*NB +: NB]);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  function automatic int slot_of(input int c, input int k);
    return ((c % NS) - k + NS) % NS;
  endfunction

  // Runs ncyc cycles starting at cycle 0 after reset release (called at a negedge).
  task automatic run(input int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      logic [NS-1:0] e_rz, e_az, e_cal, e_smp, e_xf;
      int idx, mode;
      e_rz = '0; e_az = '0; e_cal = '0; e_smp = '0; e_xf = '0;
      for (int k = 0; k < NS; k++) begin
        case (slot_of(c, k))
          0: e_rz[k] = 1'b1;
          1: e_az[k] = 1'b1;
          2: e_cal[k] = 1'b1;
          3: e_smp[k] = 1'b1;
          15: e_xf[k] = 1'b1;
          default: ;
        endcase
      end
      chk(phase_o == 4'(c % NS), "R1", "phase", int'(phase_o), c % NS);
      chk(smp_o == e_smp, "R2", "sample strobes", int'(smp_o), int'(e_smp));
      chk(refz_o == e_rz && azero_o == e_az && cal_o == e_cal, "R3",
          "calibration strobes", int'(refz_o ^ azero_o ^ cal_o), int'(e_rz ^ e_az ^ e_cal));
      chk(((refz_o & azero_o) | (cal_o & smp_o) | (xfer_o & smp_o)) == '0, "R4",
          "overlapping strobes", int'(xfer_o & smp_o), 0);
      chk(xfer_o == e_xf, "R7", "transfer strobes", int'(xfer_o), int'(e_xf));
      for (int k = 0; k < NS; k++) begin
        int s;
        logic [NB-1:0] tr, rs;
        s = slot_of(c, k);
        tr = trial_o[k*NB +: NB];
        rs = result_o[k*NB +: NB];
        if (s <= 3) chk(tr == '0, "R8", "trial zero before conversion", int'(tr), 0);
        if (c >= 16) begin
          if (s == 4) chk(tr == 9'h100, "R5", "msb trial", int'(tr), 256);
          if (s == 13) chk(rs == expr[k], "R6", "result after last bit", int'(rs), int'(expr[k]));
          if (s == 14) chk(tr == expr[k], "R8", "trial held", int'(tr), int'(expr[k]));
          if (s == 15) chk(rs == expr[k] && tr == expr[k], "R10", "transfer word",
                           int'(rs), int'(expr[k]));
        end
      end
      // Drive this cycle's input level; sections in their sample slot capture it.
      idx = (c + (c / NS) * 5) % NS;
      mode = ((c / NS) == 5) ? 1 : ((c / NS) == 6) ? 2 : 0;
      for (int k = 0; k < NS; k++) begin
        if (slot_of(c, k) == 3) begin
          held[k]  = TAB[idx].stim;
          hmode[k] = mode;
          expr[k]  = (mode == 1) ? 9'h1FF : (mode == 2) ? 9'h000 : TAB[idx].expv;
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    for (int k = 0; k < NS; k++) begin
      held[k] = '0; expr[k] = '0; hmode[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(phase_o == 4'd0, "R9", "phase in reset", int'(phase_o), 0);
    chk(trial_o == '0 && result_o == '0, "R9", "trial/result in reset",
        int'(trial_o[NB-1:0] | result_o[NB-1:0]), 0);
    rst = 1'b0;
    run(NS * 10);
    // Reset in the middle of conversions.
    rst = 1'b1;
    @(negedge clk);
    chk(phase_o == 4'd0, "R9", "phase after mid-run reset", int'(phase_o), 0);
    chk(trial_o == '0, "R9", "trial after mid-run reset", int'(trial_o[NB-1:0]), 0);
    chk(result_o == '0, "R9", "result after mid-run reset", int'(result_o[NB-1:0]), 0);
    @(negedge clk);
    rst = 1'b0;
    run(NS * 3);
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule